// File: doc/BRIEF.md
# Serial Flash Status Reader with Programmable Capture Delay

This block is the master side of a serial flash link. It reads the flash's first status register and returns the byte it receives. It runs from the fast system clock and generates a serial clock (SCK) at exactly half that rate, so one SCK period lasts two system cycles. A one-cycle `start` begins a transaction if the block is idle. The block then lowers chip select and shifts out the read-status opcode 0x05, most significant bit first. After that it collects eight returned bits and raises `done` for one cycle, with the byte already on `status_byte`.

Returned data has two delays before it reaches the master's sampling register. The first is the flash output-valid time after the falling SCK edge. The second is the delay of the input path. Together they can exceed one SCK period. For this reason the point where each returned bit is captured is not tied to its nominal rising SCK edge. It can be moved later by a whole number of SCK periods, chosen on `lat_sel` when the transaction is accepted. SCK keeps toggling through those extra periods, so the flash keeps presenting data until the last delayed capture point. The user picks the setting that places every capture inside the flash's valid-data window. That window is the SCK period, less the worst-case output-valid time, plus the output hold time.

Top module: `spi_status_reader`

## Requirements
- R1: A synchronous active-low reset, applied at any time (including in the middle of a transaction), returns the block to idle. After reset `cs_n`=1, `sck`=0, `si`=0, `busy`=0, `done`=0 and `status_byte`=0x00.
- R2: A `start` seen high at a clock edge while idle is accepted. In the next cycle `cs_n`=0, `sck`=0 and `busy`=1. From then on each SCK period is one cycle with `sck` low followed by one cycle with `sck` high.
- R3: The opcode 0x05 is sent on `si` most significant bit first, one bit per SCK period. `si` changes only at the edge that ends an `sck`-high cycle. While `sck` is high, `si` does not change. After the eighth opcode bit, `si` is 0.
- R4: `so` passes through a system-clock register. A returned bit is taken as the value of `so` at the system edge where `sck` rises. Numbering SCK periods from 0 at acceptance, data bit j (j=0 is the status register's bit 7) is taken in period 8+L+j, where L is the effective latency.
- R5: `lat_sel` is 2 bits wide and gives L: values 0, 1 and 2 give L=0, 1 and 2. The value 3 is treated as L=2.
- R6: A transaction has exactly 16+L SCK high pulses. `cs_n` returns high at the edge that ends the last pulse, and `sck` is low whenever `cs_n` is high.
- R7: The first captured bit becomes bit 7 of `status_byte`. `status_byte` changes only when a transaction completes and holds its value through the whole of the next transaction.
- R8: `done` is high for exactly one cycle. It rises at the 32+2L-th clock edge after the accepting edge. `busy` stays high from the cycle after acceptance through the `done` cycle and the cycle after it, then falls.
- R9: `cs_n` stays high for at least two cycles between transactions. With `start` held high, it is high for exactly three cycles. A `start` while busy is ignored and does not alter the transaction in progress.
- R10: L is latched at acceptance. Changing `lat_sel` during a transaction has no effect on its timing or its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, twice the SCK rate |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a status read; honoured only when idle |
| lat_sel | input | 2 | Capture postponement in SCK periods (3 acts as 2) |
| busy | output | 1 | Transaction or deselect gap in progress |
| done | output | 1 | One-cycle pulse: `status_byte` just updated |
| status_byte | output | 8 | Last status byte received |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock, idle low |
| si | output | 1 | Serial data to the flash |
| so | input | 1 | Serial data from the flash |

## Verification
Each output is due a fixed number of edges after the edge that accepts `start`. `cs_n`, `sck` and `busy` change one edge later. `done` and the new `status_byte` arrive 32+2L edges later. `busy` falls two edges after `done`. The bench drives inputs and samples outputs on the falling clock edge. It counts falling edges from the accepting edge and compares the edge count at which `done` appears with 32+2L, so a single off-by-one in the latency path shows up as a miscount. The flash model delays its output by a chosen number of half-cycles. Each setting is paired with a latency that either captures correctly or, on purpose, captures a neighbouring bit one period early or late, whose byte the bench predicts.

// File: rtl/srd_pkg.sv
// Shared types for the serial flash status reader.
// Assumes: nothing beyond the encodings defined here.
package srd_pkg;

    // Sequencer states: idle, shifting on the wire, deselect gap
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_XFER = 2'd1,
        SQ_GAP  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/srd_seq.sv
// Transaction sequencer: accepts start, runs the SCK period/phase counter,
// drives SCK and chip select, holds the deselect gap, raises done.
// Assumes: SCK is half the system clock; each SCK period is one low cycle
// followed by one high cycle; the latency is latched at acceptance.
module srd_seq
    import srd_pkg::*;
#(
    parameter int CMD_BITS  = 8,
    parameter int DATA_BITS = 8,
    parameter int MAX_LAT   = 2,
    parameter int LAT_W     = 2,
    parameter int CS_GAP    = 2,
    parameter int PER_W     = 5,
    parameter int GAP_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat_sel,
    output logic             launch,
    output logic             adv,
    output logic             fin,
    output logic             xfer,
    output logic             phase_h,
    output logic [PER_W-1:0] period,
    output logic [LAT_W-1:0] lat_q,
    output logic             sck,
    output logic             cs_n,
    output logic             busy,
    output logic             done
);

    seq_st_e          st_q;
    logic             ph_q;
    logic [PER_W-1:0] per_q;
    logic [GAP_W-1:0] gap_q;
    logic [LAT_W-1:0] lat_clamp;
    logic [PER_W-1:0] last_per;
    logic             end_h;
    logic             sck_q;
    logic             cs_q;
    logic             done_q;

    // Clamp the requested latency to the supported maximum
    always_comb begin
        lat_clamp = (lat_sel > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat_sel;
    end

    // Event decode: acceptance, period advance and final period end
    always_comb begin
        last_per = PER_W'(CMD_BITS + DATA_BITS - 1) + PER_W'(lat_q);
        end_h    = (st_q == SQ_XFER) && ph_q;
        launch   = (st_q == SQ_IDLE) && start;
        fin      = end_h && (per_q == last_per);
        adv      = end_h && !fin;
    end

    // State, phase, period, gap counter and latched latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            ph_q  <= 1'b0;
            per_q <= '0;
            gap_q <= '0;
            lat_q <= '0;
        end else begin
            case (st_q)
                SQ_IDLE: begin
                    if (start) begin
                        st_q  <= SQ_XFER;
                        ph_q  <= 1'b0;
                        per_q <= '0;
                        lat_q <= lat_clamp;
                    end
                end
                SQ_XFER: begin
                    ph_q <= !ph_q;
                    if (adv) begin
                        per_q <= per_q + 1'b1;
                    end
                    if (fin) begin
                        st_q  <= SQ_GAP;
                        gap_q <= '0;
                    end
                end
                SQ_GAP: begin
                    gap_q <= gap_q + 1'b1;
                    if (gap_q == GAP_W'(CS_GAP - 1)) begin
                        st_q <= SQ_IDLE;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    // Registered pin drivers: SCK, chip select and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q  <= 1'b0;
            cs_q   <= 1'b1;
            done_q <= 1'b0;
        end else begin
            sck_q  <= (st_q == SQ_XFER) && !ph_q;
            done_q <= fin;
            if (launch) begin
                cs_q <= 1'b0;
            end else if (fin) begin
                cs_q <= 1'b1;
            end
        end
    end

    assign xfer    = (st_q == SQ_XFER);
    assign phase_h = ph_q;
    assign period  = per_q;
    assign sck     = sck_q;
    assign cs_n    = cs_q;
    assign done    = done_q;
    assign busy    = (st_q != SQ_IDLE);

    // Checker state: consecutive cycles with chip select high (saturating)
    logic [GAP_W-1:0] hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= GAP_W'(CS_GAP);
        end else if (cs_q) begin
            if (hi_cnt != GAP_W'(CS_GAP)) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R9: chip select is reasserted only after the minimum deselect time
    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_cnt >= GAP_W'(CS_GAP)));

    // R6: SCK rests low while the flash is deselected
    p_sck_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R2: every SCK high phase lasts exactly one system cycle
    p_sck_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sck |=> !sck);

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: busy covers the done cycle
    p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R10: latched latency never moves while a transaction is running
    p_lat_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != SQ_IDLE) |=> ((st_q == SQ_IDLE) || $stable(lat_q)));

endmodule

// File: rtl/srd_tx.sv
// Command transmitter: shifts the read-status opcode out on SI, MSB first.
// Assumes: launch loads the first bit with SCK low; adv marks the edge ending
// an SCK-high cycle, so SI moves only with the falling SCK edge (mode 0).
module srd_tx #(
    parameter int               CMD_BITS = 8,
    parameter logic [CMD_BITS-1:0] OPCODE = 8'h05
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic adv,
    input  logic fin,
    input  logic xfer,
    input  logic phase_h,
    output logic si
);

    logic [CMD_BITS-1:0] sh_q;

    // Opcode shift register; zeros follow the last command bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (launch) begin
            sh_q <= OPCODE;
        end else if (fin) begin
            sh_q <= '0;
        end else if (adv) begin
            sh_q <= {sh_q[CMD_BITS-2:0], 1'b0};
        end
    end

    assign si = sh_q[CMD_BITS-1];

    // R3: SI holds across the rising SCK edge that ends each low cycle
    p_si_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !phase_h) |=> $stable(si));

endmodule

// File: rtl/srd_rx.sv
// Response receiver: registers SO, opens the capture window after the command
// plus the latched latency, assembles the byte MSB first and publishes it.
// Assumes: sample marks the edge ending each SCK-high cycle; the SO register
// then holds the pin value seen at the rising SCK edge of that period.
module srd_rx #(
    parameter int CMD_BITS  = 8,
    parameter int DATA_BITS = 8,
    parameter int LAT_W     = 2,
    parameter int PER_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 so,
    input  logic                 sample,
    input  logic                 fin,
    input  logic [PER_W-1:0]     period,
    input  logic [LAT_W-1:0]     lat_q,
    output logic [DATA_BITS-1:0] status_byte
);

    localparam int CW = $clog2(DATA_BITS + 1);

    logic                 so_q;
    logic [DATA_BITS-1:0] sh_q;
    logic [DATA_BITS-1:0] out_q;
    logic [PER_W-1:0]     first_cap;
    logic                 cap;

    // Capture window opens at the command length plus the latency
    always_comb begin
        first_cap = PER_W'(CMD_BITS) + PER_W'(lat_q);
        cap       = sample && (period >= first_cap);
    end

    // Input register on the SO pin
    always_ff @(posedge clk) begin
        if (!rst_n) so_q <= 1'b0;
        else        so_q <= so;
    end

    // Assembly shift register and the published status byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            out_q <= '0;
        end else begin
            if (cap) sh_q  <= {sh_q[DATA_BITS-2:0], so_q};
            if (fin) out_q <= {sh_q[DATA_BITS-2:0], so_q};
        end
    end

    assign status_byte = out_q;

    // Checker state: captures taken in the current transaction
    logic [CW-1:0] cap_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || fin) cap_cnt <= '0;
        else if (cap)      cap_cnt <= cap_cnt + 1'b1;
    end

    // R4: the final period carries the last of exactly DATA_BITS captures
    p_capture_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (cap && (cap_cnt == CW'(DATA_BITS - 1))));

endmodule

// File: rtl/spi_status_reader.sv
// Serial flash status reader, top level. Reads the first status register
// with opcode 0x05 and postpones data capture by a selectable number of SCK
// periods to absorb flash output-valid time plus the input path delay.
// Assumes: SCK at half the system clock, mode 0, a single flash device.
module spi_status_reader #(
    parameter int               CMD_BITS  = 8,
    parameter int               DATA_BITS = 8,
    parameter int               MAX_LAT   = 2,
    parameter int               LAT_W     = 2,
    parameter int               CS_GAP    = 2,
    parameter logic [CMD_BITS-1:0] OPCODE = 8'h05
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [LAT_W-1:0]     lat_sel,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] status_byte,
    output logic                 cs_n,
    output logic                 sck,
    output logic                 si,
    input  logic                 so
);

    localparam int PER_W = $clog2(CMD_BITS + DATA_BITS + MAX_LAT);
    localparam int GAP_W = $clog2(CS_GAP + 1);

    logic             launch;
    logic             adv;
    logic             fin;
    logic             xfer;
    logic             phase_h;
    logic [PER_W-1:0] period;
    logic [LAT_W-1:0] lat_q;

    srd_seq #(
        .CMD_BITS (CMD_BITS),
        .DATA_BITS(DATA_BITS),
        .MAX_LAT  (MAX_LAT),
        .LAT_W    (LAT_W),
        .CS_GAP   (CS_GAP),
        .PER_W    (PER_W),
        .GAP_W    (GAP_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .lat_sel(lat_sel),
        .launch (launch),
        .adv    (adv),
        .fin    (fin),
        .xfer   (xfer),
        .phase_h(phase_h),
        .period (period),
        .lat_q  (lat_q),
        .sck    (sck),
        .cs_n   (cs_n),
        .busy   (busy),
        .done   (done)
    );

    srd_tx #(
        .CMD_BITS(CMD_BITS),
        .OPCODE  (OPCODE)
    ) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .launch (launch),
        .adv    (adv),
        .fin    (fin),
        .xfer   (xfer),
        .phase_h(phase_h),
        .si     (si)
    );

    srd_rx #(
        .CMD_BITS (CMD_BITS),
        .DATA_BITS(DATA_BITS),
        .LAT_W    (LAT_W),
        .PER_W    (PER_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .so         (so),
        .sample     (adv || fin),
        .fin        (fin),
        .period     (period),
        .lat_q      (lat_q),
        .status_byte(status_byte)
    );

endmodule

// File: tb/tb_spi_status_reader.sv
module tb_spi_status_reader;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] lat_sel = 2'd0;
    logic       busy, done, cs_n, sck, si;
    logic [7:0] status_byte;
    logic       so = 1'b1;

    int tests = 0;
    int fails = 0;

    spi_status_reader dut (
        .clk(clk), .rst_n(rst_n), .start(start), .lat_sel(lat_sel),
        .busy(busy), .done(done), .status_byte(status_byte),
        .cs_n(cs_n), .sck(sck), .si(si), .so(so)
    );

    always #4 clk = ~clk;

    // Flash model: new bit after each falling SCK, delayed by 4+8*f_k ns
    logic [7:0] f_stat = 8'h00;
    int         f_k = 0;
    logic [7:0] f_hist = 8'hFF;
    logic       f_raw = 1'b1;
    logic       f_psck = 1'b0;
    int         f_fall = 0;
    int         f_rise = 0;
    logic [7:0] f_cmd = 8'h00;
    logic [7:0] f_cmd_got = 8'h00;

    always @(negedge clk) begin
        if (cs_n) begin
            f_raw = 1'b1; f_fall = 0; f_rise = 0; f_cmd = 8'h00;
        end else begin
            if (sck && !f_psck && f_rise < 8) begin
                if (f_rise == 0) f_cmd_got = 8'h00;
                f_cmd = {f_cmd[6:0], si};
                f_rise++;
                if (f_rise == 8) f_cmd_got = f_cmd;
            end
            if (!sck && f_psck) begin
                f_fall++;
                if (f_fall >= 8 && f_fall <= 15) f_raw = f_stat[15 - f_fall];
                else                             f_raw = 1'b1;
            end
        end
        f_psck = sck;
        f_hist = {f_hist[6:0], f_raw};
        so = f_hist[f_k];
    end

    // Vectors: {lat_sel[20:19], delay step[18:16], flash status[15:8], expected[7:0]}
    localparam int NV = 8;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {2'd0, 3'd0, 8'hA5, 8'hA5},
        {2'd1, 3'd1, 8'h3C, 8'h3C},
        {2'd1, 3'd2, 8'hC3, 8'hC3},
        {2'd2, 3'd3, 8'h5A, 8'h5A},
        {2'd2, 3'd4, 8'h81, 8'h81},
        {2'd3, 3'd3, 8'h7E, 8'h7E},
        {2'd0, 3'd1, 8'hB2, 8'hD9},
        {2'd1, 3'd0, 8'hB2, 8'h65}
    };

    logic [7:0] prev_byte = 8'h00;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input logic [1:0] lat, input int k, input logic [7:0] stat,
                           input logic [7:0] exp, input bit poke, input string req);
        int n = 0, rises = 0, eff;
        bit si_bad = 0;
        logic psck, psi;
        eff = (lat > 2'd2) ? 2 : int'(lat);
        f_stat = stat; f_k = k;
        @(negedge clk); start = 1'b1; lat_sel = lat;
        @(negedge clk); start = 1'b0;
        chk(cs_n == 0 && sck == 0 && busy == 1, "R2", "select after accept",
            {cs_n, sck, busy}, 3'b001);
        psck = sck; psi = si;
        while (!done && n < 200) begin
            @(negedge clk); n++;
            if (sck && !psck) rises++;
            if (sck && si !== psi) si_bad = 1;
            psck = sck; psi = si;
            if (poke && n == 10) begin start = 1'b1; lat_sel = ~lat; end
            if (poke && n == 11) start = 1'b0;
            if (n == 20) chk(status_byte == prev_byte, "R7", "byte held mid-transfer",
                             status_byte, prev_byte);
        end
        chk(n == 32 + 2 * eff, (poke ? "R10" : "R8"), "done edge count", n, 32 + 2 * eff);
        chk(status_byte == exp, req, "status byte", status_byte, exp);
        chk(rises == 16 + eff, "R6", "sck pulses", rises, 16 + eff);
        chk(cs_n == 1, "R6", "deselect at done", cs_n, 1);
        chk(f_cmd_got == 8'h05, "R3", "opcode seen by flash", f_cmd_got, 8'h05);
        chk(!si_bad, "R3", "si stable while sck high", si_bad, 0);
        @(negedge clk);
        chk(done == 0 && busy == 1, "R8", "done pulse width / busy in gap", {done, busy}, 2'b01);
        @(negedge clk);
        chk(busy == 0, "R8", "busy released", busy, 0);
        chk(status_byte == exp, (poke ? "R9" : "R7"), "byte held after done", status_byte, exp);
        prev_byte = status_byte;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cs_n == 1 && sck == 0 && si == 0 && busy == 0 && done == 0 && status_byte == 0,
            "R1", "reset outputs", {cs_n, sck, si, busy, done, status_byte}, 13'h1000);
        rst_n = 1'b1;
        @(negedge clk);

        // Main vectors: R4 ideal/matched latency, R5 selection and clamp
        for (int i = 0; i < NV; i++) begin
            run_txn(VEC[i][20:19], int'(VEC[i][18:16]), VEC[i][15:8], VEC[i][7:0], 1'b0,
                    (i == 0) ? "R4" : "R5");
        end

        // R9, R10: start and latency changes while busy are ignored
        run_txn(2'd1, 1, 8'h96, 8'h96, 1'b1, "R10");

        // R9: back-to-back with start held high, deselect time is exactly 3 cycles
        begin
            int n = 0, hi = 0;
            f_stat = 8'h4D; f_k = 0;
            @(negedge clk); start = 1'b1; lat_sel = 2'd0;
            while (!done && n < 200) begin @(negedge clk); n++; end
            chk(status_byte == 8'h4D, "R7", "first of back-to-back", status_byte, 8'h4D);
            f_stat = 8'hE1;
            while (cs_n && hi < 20) begin hi++; @(negedge clk); end
            start = 1'b0;
            chk(hi == 3, "R9", "deselect cycles", hi, 3);
            n = 0;
            while (!done && n < 200) begin @(negedge clk); n++; end
            chk(status_byte == 8'hE1, "R7", "second of back-to-back", status_byte, 8'hE1);
            repeat (3) @(negedge clk);
            prev_byte = status_byte;
        end

        // R1: reset in the middle of a transaction
        f_stat = 8'h33; f_k = 3;
        @(negedge clk); start = 1'b1; lat_sel = 2'd2;
        @(negedge clk); start = 1'b0;
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(cs_n == 1 && sck == 0 && si == 0 && busy == 0 && done == 0 && status_byte == 0,
            "R1", "mid-transfer reset", {cs_n, sck, si, busy, done, status_byte}, 13'h1000);
        prev_byte = 8'h00;
        @(negedge clk);
        run_txn(2'd2, 3, 8'h6C, 8'h6C, 1'b0, "R5");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL R8 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule